// File: doc/BRIEF.md
# Debug Module Register Front-End

This block is the register file that a debugger reaches through a 32-bit read/write register-access port. The port carries one request per cycle: a valid strobe, a write flag, a word address and write data. One cycle later the block returns a response: the read data and an error flag. Behind the port sit the following registers:

- a control register, which carries the activation, halt, resume and system-reset requests, the hart select and a status report;
- an abstract status register, which holds the error code, the busy flag, the auto-execute mask and the data-word count;
- a command register;
- a small set of data words;
- a small set of program-buffer words.

The block owns the command-start decision. A start comes from a write to the command register, or from an access to a data word whose auto-execute bit is set. The start is refused when an error is already recorded. When the block is busy, a start attempt turns into a sticky "busy" error instead. An accepted start emits a one-cycle pulse toward the abstract command generator and sets busy. A resume request emits its own pulse so that the generator can stage the return-from-debug code, and it also sets busy. The generator ends either operation by pulsing `cmd_done`, which clears busy. Hart status is derived from the halted flags that the slot tracker supplies.

Top module: `dbg_regfront`

## Requirements
- R1: Reset clears all state. A control read then returns active=0, the hart-status field [13:12] for hart 0, authenticated bit 16 = 1 and version [23:20] = 1. The control fields are active bit 0, system reset bit 1, resume request bit 2, halt request bit 3 and hart select [11:8]. The outputs `cmd_start`, `resume_go` and `rsp_valid` stay low.
- R2: The abstract status register (address 0x16) reports in [3:0] the number of data words, which is the data storage size in bytes divided by 4. Its other fields are error [10:8], busy bit 12 and auto-execute mask [23:16].
- R3: A request in cycle N gives `rsp_valid` in cycle N+1. Data words (from 0x04) and program words (from 0x20) return the last value written to them.
- R4: A read or write of a data word while busy sets error code 1 ("busy") if the error field is 0. A non-zero error is kept unchanged. The data write itself still takes effect.
- R5: When mask bit 16+i is set, any read or write of data word i (i < 8) attempts a command start.
- R6: Writing the command register (0x17) stores the word and attempts a start. With error ≠ 0 nothing happens. With busy set, error becomes 1 and no pulse is given. Otherwise `cmd_start` pulses for one cycle with `cmd_word` updated, and busy sets.
- R7: A status write loads all eight mask bits from [23:16]. It clears the error field only when the written [10:8] equals 0.
- R8: A control write (0x10) always captures bit 0 into `dm_active`. It updates halt, resume, system reset and hart select only when the written bit 0 is 1.
- R9: A control write with bits 0 and 2 set pulses `resume_go` and sets busy.
- R10: Hart status is reported as 1 when the selected hart is halted, 0 when it is running, and 2 when the selected hart is not present (hart select ≥ NHARTS).
- R11: A read of an unmapped address returns data 0 with `rsp_err` = 1. A write to an unmapped address changes nothing.
- R12: A `cmd_done` pulse clears busy unless a start or resume sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write data |
| cmd_done | input | 1 | Command or resume finished; clears busy |
| hart_halted | input | NHARTS | Halted flag per hart from the slot tracker |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_err | output | 1 | Read of an unmapped address |
| cmd_start | output | 1 | One-cycle abstract command start pulse |
| cmd_word | output | 32 | Stored command word |
| resume_go | output | 1 | One-cycle resume staging pulse |
| halt_req | output | 1 | Halt request level |
| hart_sel | output | HSEL_W | Selected hart |
| dm_active | output | 1 | Module active bit |
| sys_reset | output | 1 | System reset request level |

## Verification
The assertions check the following relations on every cycle:
- a response follows each request;
- a start pulse only comes from an idle, error-free state and leaves busy set;
- a resume pulse also leaves busy set;
- a busy-time data access records the busy code;
- a recorded error survives every cycle without a zero-code status write;
- an inactive control write leaves the halt and hart-select state alone;
- an error response carries zero data.

The bench scenarios show the outcomes that depend on order. These cover a refused start after an error, the auto-execute trigger on a chosen word only, the clearing of busy by `cmd_done`, and the hart-status encoding for halted, running and absent harts. The cycle-accurate model in the bench follows these sequences.

// File: rtl/dbgf_pkg.sv
// Package: shared constants for the debug register front-end.
// Assumes word addressing on the request port.
package dbgf_pkg;
    localparam int ADDR_DATA0 = 'h04;
    localparam int ADDR_CTRL  = 'h10;
    localparam int ADDR_STAT  = 'h16;
    localparam int ADDR_CMD   = 'h17;
    localparam int ADDR_PROG0 = 'h20;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0,
        ERR_BUSY = 3'd1
    } err_code_t;

    localparam logic [1:0] HS_RUNNING = 2'd0;
    localparam logic [1:0] HS_HALTED  = 2'd1;
    localparam logic [1:0] HS_ABSENT  = 2'd2;

    localparam logic [3:0] DM_VERSION = 4'd1;
endpackage

// File: rtl/dbgf_decode.sv
// Address decoder: classifies a word address into register groups
// and produces the word index inside the data and program ranges.
// Assumes the ranges do not overlap (true for the default sizes).
module dbgf_decode #(
    parameter int AW         = 7,
    parameter int DATA_WORDS = 4,
    parameter int PROG_WORDS = 4,
    parameter int IDX_W      = 3
) (
    input  logic [AW-1:0]    addr,
    output logic             hit_data,
    output logic             hit_prog,
    output logic             hit_ctrl,
    output logic             hit_stat,
    output logic             hit_cmd,
    output logic [IDX_W-1:0] data_idx,
    output logic [IDX_W-1:0] prog_idx
);
    import dbgf_pkg::*;

    // Range compare and offset for every register group.
    always_comb begin
        int a;
        a        = int'(addr);
        hit_data = (a >= ADDR_DATA0) && (a < ADDR_DATA0 + DATA_WORDS);
        hit_prog = (a >= ADDR_PROG0) && (a < ADDR_PROG0 + PROG_WORDS);
        hit_ctrl = (a == ADDR_CTRL);
        hit_stat = (a == ADDR_STAT);
        hit_cmd  = (a == ADDR_CMD);
        data_idx = IDX_W'(a - ADDR_DATA0);
        prog_idx = IDX_W'(a - ADDR_PROG0);
    end
endmodule

// File: rtl/dbgf_words.sv
// Word storage: N 32-bit registers with one write port and one read port.
// Used for both the data words and the program-buffer words.
module dbgf_words #(
    parameter int N     = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    logic [31:0] words [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        logic [31:0] word_q;
        // Hold one word; load it when this index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (we && (widx == IDX_W'(g)))
                word_q <= wdata;
        end
        assign words[g] = word_q;
    end

    // Select the addressed word for reading.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < N; k++)
            if (ridx == IDX_W'(k)) rdata = words[k];
    end
endmodule

// File: rtl/dbgf_abs.sv
// Abstract command state: busy flag, sticky error, auto-execute mask,
// command word and the start decision. Assumes at most one request per cycle.
module dbgf_abs #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_acc,
    input  logic [IDX_W-1:0] data_idx,
    input  logic             stat_wr,
    input  logic             cmd_wr,
    input  logic [31:0]      wdata,
    input  logic             resume_set,
    input  logic             done,
    output logic             busy,
    output logic [2:0]       err,
    output logic [7:0]       auto_mask,
    output logic [31:0]      cmd_word,
    output logic             cmd_start
);
    import dbgf_pkg::*;

    logic        busy_q, busy_n;
    logic [2:0]  err_q, err_n;
    logic [7:0]  auto_q, auto_n;
    logic [31:0] cmd_q;
    logic        start_q, start_n;
    logic        auto_hit, start_req;

    // An access to a data word whose mask bit is set.
    assign auto_hit  = data_acc && (int'(data_idx) < 8) && auto_q[data_idx[2:0]];
    assign start_req = cmd_wr || auto_hit;

    // Next-state for busy, error, mask and the start pulse.
    always_comb begin
        busy_n  = busy_q;
        err_n   = err_q;
        auto_n  = auto_q;
        start_n = 1'b0;
        if (data_acc && busy_q && err_q == ERR_NONE) err_n = ERR_BUSY;
        if (stat_wr) begin
            auto_n = wdata[23:16];
            if (wdata[10:8] == ERR_NONE) err_n = ERR_NONE;
        end
        if (start_req && err_q == ERR_NONE) begin
            if (busy_q) err_n = ERR_BUSY;
            else        start_n = 1'b1;
        end
        if (start_n || resume_set) busy_n = 1'b1;
        else if (done)             busy_n = 1'b0;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            err_q   <= ERR_NONE;
            auto_q  <= '0;
            cmd_q   <= '0;
            start_q <= 1'b0;
        end else begin
            busy_q  <= busy_n;
            err_q   <= err_n;
            auto_q  <= auto_n;
            start_q <= start_n;
            if (cmd_wr) cmd_q <= wdata;
        end
    end

    assign busy      = busy_q;
    assign err       = err_q;
    assign auto_mask = auto_q;
    assign cmd_word  = cmd_q;
    assign cmd_start = start_q;
endmodule

// File: rtl/dbg_regfront.sv
// Debug register front-end top: request decode, control register,
// hart status, read multiplexer and registered response.
// Assumes one request per cycle and a response one cycle later.
module dbg_regfront #(
    parameter int AW         = 7,
    parameter int DATA_WORDS = 4,
    parameter int PROG_WORDS = 4,
    parameter int NHARTS     = 4,
    parameter int HSEL_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              cmd_done,
    input  logic [NHARTS-1:0] hart_halted,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              cmd_start,
    output logic [31:0]       cmd_word,
    output logic              resume_go,
    output logic              halt_req,
    output logic [HSEL_W-1:0] hart_sel,
    output logic              dm_active,
    output logic              sys_reset
);
    import dbgf_pkg::*;

    localparam int MAXW  = (DATA_WORDS > PROG_WORDS) ? DATA_WORDS : PROG_WORDS;
    localparam int IDX_W = (MAXW > 8) ? $clog2(MAXW) : 3;
    localparam logic [3:0] DCOUNT = 4'(DATA_WORDS);

    logic             hit_data, hit_prog, hit_ctrl, hit_stat, hit_cmd, hit_any;
    logic [IDX_W-1:0] data_idx, prog_idx;
    logic             wr, rd;
    logic [31:0]      data_rd, prog_rd, rd_mux, ctrl_val, stat_val;
    logic             busy_w;
    logic [2:0]       err_w;
    logic [7:0]       auto_w;
    logic             active_q, halt_q, resume_q, sysrst_q;
    logic [HSEL_W-1:0] hsel_q;
    logic [1:0]       hstat;
    logic             ctrl_wr, resume_set;
    logic             rsp_valid_q, rsp_err_q, resume_go_q;
    logic [31:0]      rsp_rdata_q;

    dbgf_decode #(.AW(AW), .DATA_WORDS(DATA_WORDS), .PROG_WORDS(PROG_WORDS), .IDX_W(IDX_W)) u_dec (
        .addr(req_addr), .hit_data(hit_data), .hit_prog(hit_prog), .hit_ctrl(hit_ctrl),
        .hit_stat(hit_stat), .hit_cmd(hit_cmd), .data_idx(data_idx), .prog_idx(prog_idx)
    );

    assign wr      = req_valid && req_write;
    assign rd      = req_valid && !req_write;
    assign hit_any = hit_data || hit_prog || hit_ctrl || hit_stat || hit_cmd;
    assign ctrl_wr = wr && hit_ctrl;
    assign resume_set = ctrl_wr && req_wdata[0] && req_wdata[2];

    dbgf_words #(.N(DATA_WORDS), .IDX_W(IDX_W)) u_data (
        .clk(clk), .rst_n(rst_n), .we(wr && hit_data), .widx(data_idx),
        .wdata(req_wdata), .ridx(data_idx), .rdata(data_rd)
    );

    dbgf_words #(.N(PROG_WORDS), .IDX_W(IDX_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .we(wr && hit_prog), .widx(prog_idx),
        .wdata(req_wdata), .ridx(prog_idx), .rdata(prog_rd)
    );

    dbgf_abs #(.IDX_W(IDX_W)) u_abs (
        .clk(clk), .rst_n(rst_n), .data_acc(req_valid && hit_data), .data_idx(data_idx),
        .stat_wr(wr && hit_stat), .cmd_wr(wr && hit_cmd), .wdata(req_wdata),
        .resume_set(resume_set), .done(cmd_done), .busy(busy_w), .err(err_w),
        .auto_mask(auto_w), .cmd_word(cmd_word), .cmd_start(cmd_start)
    );

    // Control register: active always captured, the rest only when activating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            halt_q   <= 1'b0;
            resume_q <= 1'b0;
            sysrst_q <= 1'b0;
            hsel_q   <= '0;
        end else if (ctrl_wr) begin
            active_q <= req_wdata[0];
            if (req_wdata[0]) begin
                sysrst_q <= req_wdata[1];
                resume_q <= req_wdata[2];
                halt_q   <= req_wdata[3];
                hsel_q   <= req_wdata[8 +: HSEL_W];
            end
        end
    end

    // Hart status of the selected hart.
    always_comb begin
        hstat = HS_ABSENT;
        for (int h = 0; h < NHARTS; h++)
            if (hsel_q == HSEL_W'(h)) hstat = hart_halted[h] ? HS_HALTED : HS_RUNNING;
    end

    // Read images of the control and status registers.
    always_comb begin
        ctrl_val              = '0;
        ctrl_val[0]           = active_q;
        ctrl_val[1]           = sysrst_q;
        ctrl_val[2]           = resume_q;
        ctrl_val[3]           = halt_q;
        ctrl_val[8 +: HSEL_W] = hsel_q;
        ctrl_val[13:12]       = hstat;
        ctrl_val[16]          = 1'b1;
        ctrl_val[23:20]       = DM_VERSION;
        stat_val              = '0;
        stat_val[3:0]         = DCOUNT;
        stat_val[10:8]        = err_w;
        stat_val[12]          = busy_w;
        stat_val[23:16]       = auto_w;
    end

    // Read multiplexer over all register groups.
    always_comb begin
        rd_mux = '0;
        if (hit_data)      rd_mux = data_rd;
        else if (hit_prog) rd_mux = prog_rd;
        else if (hit_ctrl) rd_mux = ctrl_val;
        else if (hit_stat) rd_mux = stat_val;
        else if (hit_cmd)  rd_mux = cmd_word;
    end

    // Registered response and resume pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
            rsp_err_q   <= 1'b0;
            resume_go_q <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_rdata_q <= rd ? rd_mux : '0;
            rsp_err_q   <= rd && !hit_any;
            resume_go_q <= resume_set;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;
    assign rsp_err   = rsp_err_q;
    assign resume_go = resume_go_q;
    assign halt_req  = halt_q;
    assign hart_sel  = hsel_q;
    assign dm_active = active_q;
    assign sys_reset = sysrst_q;
endmodule

// File: rtl/dbgf_chk.sv
// Checker for the debug register front-end; attached by bind below.
// Observes ports plus the busy flag and error field of the command state.
module dbgf_chk #(
    parameter int AW         = 7,
    parameter int DATA_WORDS = 4,
    parameter int HSEL_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [AW-1:0]     req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic              cmd_start,
    input logic              resume_go,
    input logic              halt_req,
    input logic [HSEL_W-1:0] hart_sel,
    input logic              dm_active,
    input logic              busy,
    input logic [2:0]        err
);
    import dbgf_pkg::*;

    logic data_hit, stat_clear, ctrl_off;
    assign data_hit   = req_valid && (int'(req_addr) >= ADDR_DATA0) &&
                        (int'(req_addr) < ADDR_DATA0 + DATA_WORDS);
    assign stat_clear = req_valid && req_write && (int'(req_addr) == ADDR_STAT) &&
                        (req_wdata[10:8] == 3'd0);
    assign ctrl_off   = req_valid && req_write && (int'(req_addr) == ADDR_CTRL) && !req_wdata[0];

    p_rsp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_busy_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && busy && err == 3'd0) |=> err == 3'd1);
    p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> ($past(busy) == 1'b0 && $past(err) == 3'd0));
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> busy);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err != 3'd0 && !stat_clear) |=> err == $past(err));
    p_inactive_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off |=> ($stable(halt_req) && $stable(hart_sel) && !dm_active));
    p_resume_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resume_go |-> busy);
    p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_rdata == 32'd0);
endmodule

bind dbg_regfront dbgf_chk #(.AW(AW), .DATA_WORDS(DATA_WORDS), .HSEL_W(HSEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cmd_start(cmd_start),
    .resume_go(resume_go), .halt_req(halt_req), .hart_sel(hart_sel),
    .dm_active(dm_active), .busy(busy_w), .err(err_w)
);

// File: tb/dbg_regfront_tb.sv
// Bench: behavioural reference model stepped once per clock and
// compared with every output one nanosecond after each rising edge.
`timescale 1ns/1ps
module dbg_regfront_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, cmd_done = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  halted_in = '0;
    logic        rsp_valid, rsp_err, cmd_start, resume_go, halt_req, dm_active, sys_reset;
    logic [31:0] rsp_rdata, cmd_word;
    logic [3:0]  hart_sel;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dbg_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cmd_done(cmd_done),
        .hart_halted(halted_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .cmd_start(cmd_start), .cmd_word(cmd_word),
        .resume_go(resume_go), .halt_req(halt_req), .hart_sel(hart_sel),
        .dm_active(dm_active), .sys_reset(sys_reset)
    );

    // Reference model state.
    int unsigned m_data [4];
    int unsigned m_prog [4];
    int unsigned m_cmd = 0;
    int m_auto = 0, m_err = 0;
    bit m_busy = 0, m_active = 0, m_halt = 0, m_resume = 0, m_rst = 0;
    int m_hsel = 0;
    bit e_valid = 0, e_err = 0, e_start = 0, e_resume = 0;
    int unsigned e_rdata = 0;

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned ctrl_img();
        int unsigned v = 0;
        int hs;
        hs = (m_hsel < 4) ? (halted_in[m_hsel] ? 1 : 0) : 2;
        v = v | int'(m_active) | (int'(m_rst) << 1) | (int'(m_resume) << 2) | (int'(m_halt) << 3);
        v = v | (m_hsel << 8) | (hs << 12) | (1 << 16) | (1 << 20);
        return v;
    endfunction

    function automatic int unsigned stat_img();
        return 4 | (m_err << 8) | (int'(m_busy) << 12) | (m_auto << 16);
    endfunction

    task automatic step(input bit v, input bit w, input int a, input int unsigned d,
                        input bit dn, input string tag);
        bit b0, start_req, busy_set;
        int e0;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = 7'(a); req_wdata = d; cmd_done = dn;
        b0 = m_busy; e0 = m_err; start_req = 0; busy_set = 0;
        e_valid = v; e_rdata = 0; e_err = 0; e_start = 0; e_resume = 0;
        if (v) begin
            if (a >= 'h04 && a < 'h08) begin
                if (!w) e_rdata = m_data[a-'h04]; else m_data[a-'h04] = d;
                if (b0 && e0 == 0) m_err = 1;
                if (((m_auto >> (a-'h04)) & 1) == 1) start_req = 1;
            end else if (a >= 'h20 && a < 'h24) begin
                if (!w) e_rdata = m_prog[a-'h20]; else m_prog[a-'h20] = d;
            end else if (a == 'h10) begin
                if (!w) e_rdata = ctrl_img();
                else begin
                    m_active = d[0];
                    if (d[0]) begin
                        m_rst = d[1]; m_resume = d[2]; m_halt = d[3]; m_hsel = int'(d[11:8]);
                        if (d[2]) begin e_resume = 1; busy_set = 1; end
                    end
                end
            end else if (a == 'h16) begin
                if (!w) e_rdata = stat_img();
                else begin
                    m_auto = int'(d[23:16]);
                    if (d[10:8] == 0) m_err = 0;
                end
            end else if (a == 'h17) begin
                if (!w) e_rdata = m_cmd; else begin m_cmd = d; start_req = 1; end
            end else if (!w) e_err = 1;
        end
        if (start_req && e0 == 0) begin
            if (b0) m_err = 1;
            else begin e_start = 1; busy_set = 1; end
        end
        if (busy_set) m_busy = 1; else if (dn) m_busy = 0;
        @(posedge clk); #1;
        cmp(tag, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
        cmp(tag, "rsp_rdata", rsp_rdata, e_rdata);
        cmp(tag, "rsp_err", 32'(rsp_err), 32'(e_err));
        cmp(tag, "cmd_start", 32'(cmd_start), 32'(e_start));
        cmp(tag, "resume_go", 32'(resume_go), 32'(e_resume));
        cmp(tag, "cmd_word", cmd_word, m_cmd);
        cmp(tag, "halt_req", 32'(halt_req), 32'(m_halt));
        cmp(tag, "hart_sel", 32'(hart_sel), 32'(m_hsel));
        cmp(tag, "dm_active", 32'(dm_active), 32'(m_active));
        cmp(tag, "sys_reset", 32'(sys_reset), 32'(m_rst));
    endtask

    task automatic rd(input int a, input string tag);  step(1, 0, a, 0, 0, tag); endtask
    task automatic wr(input int a, input int unsigned d, input string tag); step(1, 1, a, d, 0, tag); endtask
    task automatic idle(input bit dn, input string tag); step(0, 0, 0, 0, dn, tag); endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_data[i] = 0; m_prog[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and constant fields.
        idle(0, "R1");
        rd('h10, "R1 R10 ctrl after reset");
        // R2: data count.
        rd('h16, "R2 status");
        // R3: storage read-back.
        for (int i = 0; i < 4; i++) wr('h04 + i, 32'hA000_0000 + i * 17, "R3 data write");
        for (int i = 0; i < 4; i++) rd('h04 + i, "R3 data read");
        wr('h21, 32'hDEAD_BEEF, "R3 prog write");
        wr('h23, 32'h1234_5678, "R3 prog write");
        rd('h21, "R3 prog read");
        rd('h23, "R3 prog read");
        // R11: unmapped accesses.
        rd('h08, "R11 unmapped read");
        rd('h30, "R11 unmapped read");
        wr('h24, 32'hFFFF_FFFF, "R11 unmapped write");
        wr('h08, 32'hFFFF_FFFF, "R11 unmapped write");
        rd('h23, "R11 neighbour unchanged");
        rd('h07, "R11 neighbour unchanged");
        // R8: inactive control write leaves other fields.
        wr('h10, 32'h0000_030A, "R8 inactive write");
        rd('h10, "R8 ctrl read");
        wr('h10, 32'h0000_0209, "R8 active write");
        // R10: hart status codes.
        halted_in = 4'b0100;
        rd('h10, "R10 halted");
        halted_in = 4'b0000;
        rd('h10, "R10 running");
        wr('h10, 32'h0000_0501, "R10 select absent hart");
        rd('h10, "R10 absent");
        wr('h10, 32'h0000_0101, "R8 reselect");
        // R6, R4, R7, R12: command flow and sticky error.
        wr('h17, 32'h0022_1001, "R6 command start");
        rd('h16, "R6 busy visible");
        wr('h17, 32'h0022_1002, "R6 start while busy");
        rd('h16, "R6 busy error");
        rd('h04, "R4 data access with error kept");
        wr('h16, 32'h0000_0100, "R7 nonzero code keeps error");
        rd('h16, "R7 error kept");
        idle(1, "R12 done");
        rd('h16, "R12 busy cleared");
        wr('h17, 32'h0022_1003, "R6 refused with error");
        wr('h16, 32'h0000_0000, "R7 clear error");
        rd('h16, "R7 error cleared");
        wr('h17, 32'h0022_1004, "R6 start again");
        wr('h05, 32'h5555_0000, "R4 data write while busy");
        rd('h05, "R4 write still stored");
        rd('h16, "R4 busy error set");
        idle(1, "R12 done");
        wr('h16, 32'h0000_0000, "R7 clear error");
        // R5: auto-execute on data word 2 only.
        wr('h16, 32'h0004_0000, "R5 set mask bit 2");
        rd('h16, "R5 mask readback");
        rd('h06, "R5 read triggers start");
        idle(1, "R12 done");
        wr('h04, 32'h0000_0011, "R5 unmasked word no start");
        wr('h06, 32'h0000_0022, "R5 write triggers start");
        rd('h06, "R5 access while busy");
        idle(1, "R12 done");
        wr('h16, 32'h0000_0000, "R7 clear mask and error");
        rd('h06, "R5 mask off no start");
        // R9: resume request.
        wr('h10, 32'h0000_0105, "R9 resume request");
        rd('h16, "R9 busy after resume");
        wr('h17, 32'h0022_1005, "R9 start refused busy");
        idle(1, "R12 done");
        rd('h10, "R9 ctrl read");
        idle(0, "R1 quiet");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule